// File: doc/BRIEF.md
# Synchronous Serial Pin Control

This block owns the pins of a synchronous serial master/slave unit. It keeps the serial data line at a defined level between frames, and it lets software set that level through a control bit that is guarded by a companion protect bit. It decides whether the chip-select pin is driven or released. It also decides whether the clock pin carries the serial clock or is left to general-purpose port logic.

A neighbouring 8-bit shift engine tells the block three things: a frame has started, one data bit is being shifted out, and the frame has finished. The block uses these reports to follow the transfer phase. The chip-select automatic modes and the guard on level writes both depend on that phase.

Software reaches the fields through one 8-bit control register. A write takes effect on the clock edge that samples it, and the read value is always visible combinationally. All pins and the register port are plain level signals. No stream interface passes through this block, so no valid/ready handshake or back-pressure is involved.

Top module: `ssp_pin_ctrl`

## Requirements
- R1: After reset, `reg_rd_data` reads 0x02. The control register layout is: bit 0 data level, bit 1 protect, bit 2 clock-pin select, bits 4:3 chip-select mode. Bits 7:5 always read 0.
- R2: A write with bit 1 = 0, made outside the transfer phase, stores bit 0 as the data level. `sdo` takes that level after the same edge (0 gives low, 1 gives high).
- R3: A write with bit 1 = 1 leaves the data level unchanged. Bit 1 always reads back as 1.
- R4: A level write made during the transfer phase is ignored. The transfer phase runs from the cycle in which `xfer_start` is high through the cycle after the one in which `xfer_done` is high. The clock-select and mode fields of such a write are still stored.
- R5: When `xfer_bit_valid` is high, `sdo` takes `xfer_bit` after that edge. After a frame ends, `sdo` keeps the last bit shifted out.
- R6: `sck_serial` equals register bit 2 (1 = serial clock, 0 = port). `sck_oe` is high only when bit 2 is 1 and `master_sel` is 1.
- R7: In mode 11 (automatic output) with `master_sel` = 1, `cs_oe` is 1. `cs_out` is 1 outside the transfer phase and 0 inside it.
- R8: In mode 10 (automatic input/output) with `master_sel` = 1, the pin is released (`cs_oe` = 0) outside the transfer phase. Inside the phase it is driven low.
- R9: In mode 00 (port) and mode 01 (chip-select input), `cs_oe` is 0.
- R10: When `master_sel` is 0, `cs_oe` is 0 whatever the mode field holds.
- R11: The chip-select pin goes low in the cycle after `xfer_start` is sampled. It returns to its idle state two cycles after `xfer_done` is sampled. Whenever `cs_oe` is 0, `cs_out` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write value |
| reg_rd_data | output | 8 | Control register read value |
| master_sel | input | 1 | 1 = master, 0 = slave |
| xfer_start | input | 1 | Shift engine: frame begins |
| xfer_bit_valid | input | 1 | Shift engine: a bit is shifted out |
| xfer_bit | input | 1 | Value of the bit being shifted out |
| xfer_done | input | 1 | Shift engine: frame ends |
| sdo | output | 1 | Serial data output level |
| sck_serial | output | 1 | Clock pin routed to the serial clock |
| sck_oe | output | 1 | Clock pin output enable |
| cs_out | output | 1 | Chip-select pin output value |
| cs_oe | output | 1 | Chip-select pin output enable |

## Verification
Register fields and `sdo` change on the edge that samples the write or the shifted bit, so they are due one edge after the stimulus. The chip-select pin is low from one edge after `xfer_start` and is released two edges after `xfer_done`. The clock-pin enables follow the register and `master_sel` with no added delay. For each driven cycle, the driver queues the values expected just after the next rising edge. The monitor compares them 1 ns after that edge, so every result is judged in the cycle the requirements name, and a late or early change shows up as a mismatch.

// File: rtl/ssp_pin_pkg.sv
package ssp_pin_pkg;
  localparam int REG_W     = 8;
  localparam int LVL_POS   = 0;
  localparam int LOCK_POS  = 1;
  localparam int SCK_POS   = 2;
  localparam int MODE_LSB  = 3;
  localparam int MODE_W    = 2;
  localparam int USED_BITS = MODE_LSB + MODE_W;

  typedef enum logic [MODE_W-1:0] {
    CSM_PORT     = 2'b00,
    CSM_INPUT    = 2'b01,
    CSM_AUTO_IO  = 2'b10,
    CSM_AUTO_OUT = 2'b11
  } cs_mode_e;

  typedef struct packed {
    cs_mode_e cs_mode;
    logic     sck_sel;
    logic     level;
  } ctrl_fields_t;
endpackage

// File: rtl/ssp_ctrl_reg.sv
module ssp_ctrl_reg
  import ssp_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             in_xfer,
  output ctrl_fields_t     fields,
  output logic [REG_W-1:0] rd_data,
  output logic             lvl_load,
  output logic             lvl_value
);
  ctrl_fields_t f_q;
  logic         unused_wr_hi;

  assign unused_wr_hi = ^wr_data[REG_W-1:USED_BITS];

  // level is accepted only when unlocked in the same write and outside a frame
  assign lvl_load  = wr_en && !wr_data[LOCK_POS] && !in_xfer;
  assign lvl_value = wr_data[LVL_POS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_q.cs_mode <= CSM_PORT;
      f_q.sck_sel <= 1'b0;
      f_q.level   <= 1'b0;
    end else begin
      if (wr_en) begin
        f_q.cs_mode <= cs_mode_e'(wr_data[MODE_LSB +: MODE_W]);
        f_q.sck_sel <= wr_data[SCK_POS];
      end
      if (lvl_load) f_q.level <= lvl_value;
    end
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[LVL_POS]              = f_q.level;
    rd_data[LOCK_POS]             = 1'b1;
    rd_data[SCK_POS]              = f_q.sck_sel;
    rd_data[MODE_LSB +: MODE_W]   = f_q.cs_mode;
  end

  assign fields = f_q;
endmodule

// File: rtl/ssp_xfer_phase.sv
module ssp_xfer_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic phase,
  output logic in_xfer
);
  logic busy_q;
  logic done_q;

  // busy_q holds from the edge after start until the edge after the tail cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done && (busy_q || start);
      busy_q <= start || (busy_q && !done_q);
    end
  end

  assign phase   = busy_q;
  assign in_xfer = start || busy_q;
endmodule

// File: rtl/ssp_data_hold.sv
module ssp_data_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_value,
  input  logic load,
  input  logic load_value,
  output logic sdo
);
  logic sdo_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         sdo_q <= 1'b0;
    else if (bit_valid) sdo_q <= bit_value;
    else if (load)      sdo_q <= load_value;
  end

  assign sdo = sdo_q;
endmodule

// File: rtl/ssp_cs_drive.sv
module ssp_cs_drive
  import ssp_pin_pkg::*;
(
  input  cs_mode_e mode,
  input  logic     master,
  input  logic     phase,
  output logic     cs_out,
  output logic     cs_oe
);
  logic drive_low;

  always_comb begin
    cs_oe     = 1'b0;
    drive_low = 1'b0;
    if (master) begin
      unique case (mode)
        CSM_AUTO_OUT: begin
          cs_oe     = 1'b1;
          drive_low = phase;
        end
        CSM_AUTO_IO: begin
          cs_oe     = phase;
          drive_low = phase;
        end
        default: begin
          cs_oe     = 1'b0;
          drive_low = 1'b0;
        end
      endcase
    end
  end

  assign cs_out = !drive_low;
endmodule

// File: rtl/ssp_pin_ctrl.sv
module ssp_pin_ctrl
  import ssp_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             master_sel,
  input  logic             xfer_start,
  input  logic             xfer_bit_valid,
  input  logic             xfer_bit,
  input  logic             xfer_done,
  output logic             sdo,
  output logic             sck_serial,
  output logic             sck_oe,
  output logic             cs_out,
  output logic             cs_oe
);
  ctrl_fields_t fields;
  logic         phase;
  logic         in_xfer;
  logic         lvl_load;
  logic         lvl_value;

  ssp_xfer_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (xfer_start),
    .done    (xfer_done),
    .phase   (phase),
    .in_xfer (in_xfer)
  );

  ssp_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_data   (reg_wr_data),
    .in_xfer   (in_xfer),
    .fields    (fields),
    .rd_data   (reg_rd_data),
    .lvl_load  (lvl_load),
    .lvl_value (lvl_value)
  );

  ssp_data_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (xfer_bit_valid),
    .bit_value  (xfer_bit),
    .load       (lvl_load),
    .load_value (lvl_value),
    .sdo        (sdo)
  );

  ssp_cs_drive u_cs (
    .mode   (fields.cs_mode),
    .master (master_sel),
    .phase  (phase),
    .cs_out (cs_out),
    .cs_oe  (cs_oe)
  );

  assign sck_serial = fields.sck_sel;
  assign sck_oe     = fields.sck_sel && master_sel;
endmodule

// File: rtl/ssp_pin_ctrl_chk.sv
module ssp_pin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_en,
  input logic [7:0] reg_wr_data,
  input logic [7:0] reg_rd_data,
  input logic       master_sel,
  input logic       xfer_start,
  input logic       xfer_bit_valid,
  input logic       xfer_bit,
  input logic       sdo,
  input logic       sck_serial,
  input logic       sck_oe,
  input logic       cs_out,
  input logic       cs_oe,
  input logic       in_xfer
);
  AST_SLAVE_CS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> !cs_oe); // R10
  AST_CS_LOW_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_out |-> cs_oe); // R11
  AST_LOCKED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_data[1]) |=> (reg_rd_data[0] == $past(reg_rd_data[0]))); // R3
  AST_MIDFRAME_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && in_xfer) |=> (reg_rd_data[0] == $past(reg_rd_data[0]))); // R4
  AST_BIT_TO_SDO: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_bit_valid |=> (sdo == $past(xfer_bit))); // R5
  AST_SCK_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    sck_oe |-> (sck_serial && master_sel)); // R6
  AST_START_PULLS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && master_sel && reg_rd_data[4] && reg_rd_data[3] && !reg_wr_en)
      |=> (!master_sel || !cs_out)); // R7
endmodule

bind ssp_pin_ctrl ssp_pin_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_wr_en      (reg_wr_en),
  .reg_wr_data    (reg_wr_data),
  .reg_rd_data    (reg_rd_data),
  .master_sel     (master_sel),
  .xfer_start     (xfer_start),
  .xfer_bit_valid (xfer_bit_valid),
  .xfer_bit       (xfer_bit),
  .sdo            (sdo),
  .sck_serial     (sck_serial),
  .sck_oe         (sck_oe),
  .cs_out         (cs_out),
  .cs_oe          (cs_oe),
  .in_xfer        (in_xfer)
);

// File: tb/test_ssp_pin_ctrl.sv
`timescale 1ns/1ps
module test_ssp_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic       master_sel = 1'b1;
  logic       xfer_start = 1'b0;
  logic       xfer_bit_valid = 1'b0;
  logic       xfer_bit = 1'b0;
  logic       xfer_done = 1'b0;
  logic       sdo, sck_serial, sck_oe, cs_out, cs_oe;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic       sdo;
    logic       cs_out;
    logic       cs_oe;
    logic       sck_oe;
    logic [7:0] rd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  ssp_pin_ctrl i_ssp_pin_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr_en      (reg_wr_en),
    .reg_wr_data    (reg_wr_data),
    .reg_rd_data    (reg_rd_data),
    .master_sel     (master_sel),
    .xfer_start     (xfer_start),
    .xfer_bit_valid (xfer_bit_valid),
    .xfer_bit       (xfer_bit),
    .xfer_done      (xfer_done),
    .sdo            (sdo),
    .sck_serial     (sck_serial),
    .sck_oe         (sck_oe),
    .cs_out         (cs_out),
    .cs_oe          (cs_oe)
  );

  // monitor: compares 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{sdo: sdo, cs_out: cs_out, cs_oe: cs_oe, sck_oe: sck_oe, rd: reg_rd_data};
      tests_run++;
      if (a != e || sck_serial != e.rd[2]) begin
        tests_failed++;
        $display("FAIL %s: actual sdo=%b cs_out=%b cs_oe=%b sck_oe=%b sck_serial=%b rd=%h expected sdo=%b cs_out=%b cs_oe=%b sck_oe=%b sck_serial=%b rd=%h",
                 t, a.sdo, a.cs_out, a.cs_oe, a.sck_oe, sck_serial, a.rd,
                 e.sdo, e.cs_out, e.cs_oe, e.sck_oe, e.rd[2], e.rd);
      end
    end
  end

  // driver: one cycle of stimulus plus the values due after its edge
  task automatic cyc(input logic wr, input logic [7:0] wd, input logic ms,
                     input logic st, input logic bv, input logic bt, input logic dn,
                     input logic e_sdo, input logic e_cso, input logic e_csoe,
                     input logic e_scko, input logic [7:0] e_rd, input string tag);
    @(negedge clk);
    reg_wr_en      = wr;
    reg_wr_data    = wd;
    master_sel     = ms;
    xfer_start     = st;
    xfer_bit_valid = bv;
    xfer_bit       = bt;
    xfer_done      = dn;
    exp_q.push_back('{sdo: e_sdo, cs_out: e_cso, cs_oe: e_csoe, sck_oe: e_scko, rd: e_rd});
    tag_q.push_back(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    //   wr wd    ms st bv bt dn  sdo cso csoe scko rd
    cyc(0, 8'h00, 1, 0, 0, 0, 0,  0, 1, 0, 0, 8'h02, "R1 reset state");
    cyc(1, 8'h01, 1, 0, 0, 0, 0,  1, 1, 0, 0, 8'h03, "R2 unlocked level write high");
    cyc(1, 8'h02, 1, 0, 0, 0, 0,  1, 1, 0, 0, 8'h03, "R3 locked write keeps level");
    cyc(1, 8'h1E, 1, 0, 0, 0, 0,  1, 1, 1, 1, 8'h1F, "R7 R6 auto-out idle high");
    cyc(0, 8'h00, 1, 1, 0, 0, 0,  1, 0, 1, 1, 8'h1F, "R11 R7 start pulls cs low");
    cyc(0, 8'h00, 1, 0, 1, 0, 0,  0, 0, 1, 1, 8'h1F, "R5 bit 0 shifted");
    cyc(1, 8'h1D, 1, 0, 0, 0, 0,  0, 0, 1, 1, 8'h1F, "R4 level write ignored mid-frame");
    cyc(0, 8'h00, 1, 0, 1, 1, 0,  1, 0, 1, 1, 8'h1F, "R5 bit 1 shifted");
    cyc(0, 8'h00, 1, 0, 1, 0, 0,  0, 0, 1, 1, 8'h1F, "R5 last bit 0 shifted");
    cyc(0, 8'h00, 1, 0, 0, 0, 1,  0, 0, 1, 1, 8'h1F, "R11 cs low on done edge");
    cyc(0, 8'h00, 1, 0, 0, 0, 0,  0, 1, 1, 1, 8'h1F, "R11 cs high two edges after done");
    cyc(0, 8'h00, 1, 0, 0, 0, 0,  0, 1, 1, 1, 8'h1F, "R5 last bit held");
    cyc(1, 8'h19, 1, 0, 0, 0, 0,  1, 1, 1, 0, 8'h1B, "R2 R6 level write and port clock");
    cyc(1, 8'h12, 1, 0, 0, 0, 0,  1, 1, 0, 0, 8'h13, "R8 auto-io idle released");
    cyc(0, 8'h00, 1, 1, 0, 0, 0,  1, 0, 1, 0, 8'h13, "R8 auto-io drives low");
    cyc(0, 8'h00, 1, 0, 0, 0, 0,  1, 0, 1, 0, 8'h13, "R8 auto-io low mid-frame");
    cyc(0, 8'h00, 1, 0, 0, 0, 1,  1, 0, 1, 0, 8'h13, "R11 auto-io low on done edge");
    cyc(1, 8'h10, 1, 0, 0, 0, 0,  1, 1, 0, 0, 8'h13, "R4 tail-cycle write ignored, R11 release");
    cyc(1, 8'h10, 1, 0, 0, 0, 0,  0, 1, 0, 0, 8'h12, "R2 level write low");
    cyc(1, 8'h1A, 0, 0, 0, 0, 0,  0, 1, 0, 0, 8'h1A, "R10 slave auto-out released");
    cyc(1, 8'h1E, 0, 0, 0, 0, 0,  0, 1, 0, 0, 8'h1E, "R6 slave clock not driven");
    cyc(0, 8'h00, 0, 1, 0, 0, 0,  0, 1, 0, 0, 8'h1E, "R10 slave start no drive");
    cyc(0, 8'h00, 0, 0, 0, 0, 1,  0, 1, 0, 0, 8'h1E, "R10 slave done no drive");
    cyc(0, 8'h00, 0, 0, 0, 0, 0,  0, 1, 0, 0, 8'h1E, "R10 slave tail no drive");
    cyc(0, 8'h00, 1, 0, 0, 0, 0,  0, 1, 1, 1, 8'h1E, "R7 R6 master again idle high");
    cyc(1, 8'h0A, 1, 0, 0, 0, 0,  0, 1, 0, 0, 8'h0A, "R9 input mode released");
    cyc(0, 8'h00, 1, 1, 0, 0, 0,  0, 1, 0, 0, 8'h0A, "R9 input mode start");
    cyc(0, 8'h00, 1, 0, 0, 0, 1,  0, 1, 0, 0, 8'h0A, "R9 input mode done");
    cyc(0, 8'h00, 1, 0, 0, 0, 0,  0, 1, 0, 0, 8'h0A, "R9 input mode tail");
    cyc(1, 8'h02, 1, 0, 0, 0, 0,  0, 1, 0, 0, 8'h02, "R9 port mode released");
    cyc(1, 8'h01, 1, 1, 0, 0, 0,  0, 1, 0, 0, 8'h02, "R4 write on start cycle ignored");
    cyc(0, 8'h00, 1, 0, 0, 0, 1,  0, 1, 0, 0, 8'h02, "R9 port mode done");
    cyc(0, 8'h00, 1, 0, 0, 0, 0,  0, 1, 0, 0, 8'h02, "R9 port mode tail");
    cyc(1, 8'h01, 1, 0, 0, 0, 0,  1, 1, 0, 0, 8'h03, "R2 write accepted after frame");
    cyc(1, 8'hFF, 1, 0, 0, 0, 0,  1, 1, 1, 1, 8'h1F, "R1 upper bits read zero");
    @(negedge clk);
    reg_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests_failed++;
      $display("FAIL R1: %0d expected items never compared, expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests_failed++;
      $display("FAIL R1: watchdog expired, actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule